// File: doc/BRIEF.md
# Halfword-Selectable Signed Multiply Unit

This unit is the multiply stage of a 32-bit processor datapath. Each valid request carries two word operands, a 3-bit operation code, one top/bottom select bit per operand and a 64-bit accumulator split into a high and a low word. The result comes out as a low word and a high word, one clock after the request. There are three kinds of operation:

- Halfword by halfword: the two selected signed halfwords are multiplied.
- Word by halfword: a signed word is multiplied by a signed halfword, and the middle 32 bits of the 48-bit product are kept.
- Long multiply: a 32x32 multiply, signed or unsigned, with an optional 64-bit accumulate.

All modes share one signed multiplier that is one bit wider than the operands. An operand selector extends the inputs for each mode. A formatter then cuts the wide sum into the two result words. The result registers change only when a request is accepted, so the last answer stays on the outputs between requests.

Top module: `hsmul_unit`

## Requirements
- R1: With op=0 (halfword pair), the two selected halfwords are treated as signed 16-bit values and res_lo is their full signed 32-bit product. For each operand, a select bit of 0 picks bits [15:0] and a select bit of 1 picks bits [31:16].
- R2: With op=1 (word by halfword), opa is a signed 32-bit value and the halfword of opb chosen by sel_b (same bit ranges as R1) is a signed 16-bit value. res_lo is bits [47:16] of their signed 48-bit product. sel_a has no effect on the result.
- R3: For op=0 and op=1, res_hi is zero.
- R4: With op=2, {res_hi,res_lo} is the unsigned 64-bit product of opa and opb.
- R5: With op=3, {res_hi,res_lo} is the unsigned product plus {acc_hi,acc_lo}, wrapping modulo 2^64.
- R6: With op=4, {res_hi,res_lo} is the signed 64-bit product of opa and opb, both taken as two's complement.
- R7: With op=5, {res_hi,res_lo} is the signed product plus {acc_hi,acc_lo}, wrapping modulo 2^64.
- R8: op=6 and op=7 are reserved and give zero in both result words.
- R9: out_vld is high in the cycle after each cycle in which in_vld is high, and the result for that request is on res_lo/res_hi in that same cycle. Back-to-back requests give back-to-back results.
- R10: While in_vld is low, res_lo and res_hi keep their values.
- R11: While rst_n is low, out_vld, res_lo and res_hi are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Request valid |
| op | input | 3 | Operation code (see R1 to R8) |
| sel_a | input | 1 | Halfword select for opa: 0 = bottom, 1 = top |
| sel_b | input | 1 | Halfword select for opb: 0 = bottom, 1 = top |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| acc_lo | input | 32 | Accumulator low word |
| acc_hi | input | 32 | Accumulator high word |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| res_lo | output | 32 | Result low word |
| res_hi | output | 32 | Result high word |

## Verification
Two functions can fall in the same clock edge: loading a new result and holding the previous one.

- Loading and holding are provoked by mixing back-to-back request bursts with idle gaps of random length.
- A scoreboard queue pairs every out_vld pulse with the value that wide signed and unsigned reference arithmetic predicts for its request.
- After each gap, the outputs are compared against the last expected result. This shows that no stale or early capture happened.
- The vectors also cover the extreme values where sign extension and modulo wrap meet:
  - 0x8000 times 0x8000,
  - 0x80000000 times a 0x8000 halfword,
  - all-ones operands with an all-ones accumulator.

// File: rtl/hsmul_pkg.sv
package hsmul_pkg;
    typedef enum logic [2:0] {
        M_HALF  = 3'd0,
        M_WHALF = 3'd1,
        M_UMUL  = 3'd2,
        M_UMAC  = 3'd3,
        M_SMUL  = 3'd4,
        M_SMAC  = 3'd5,
        M_RSV6  = 3'd6,
        M_RSV7  = 3'd7
    } mode_e;
endpackage

// File: rtl/hsmul_opsel.sv
module hsmul_opsel
    import hsmul_pkg::*;
#(
    parameter int W = 32
) (
    input  mode_e               mode,
    input  logic                sel_a,
    input  logic                sel_b,
    input  logic [W-1:0]        a,
    input  logic [W-1:0]        b,
    output logic signed [W:0]   x,
    output logic signed [W:0]   y
);
    localparam int H = W / 2;

    logic [H-1:0] half_a;
    logic [H-1:0] half_b;

    always_comb begin
        half_a = sel_a ? a[W-1:H] : a[H-1:0];
        half_b = sel_b ? b[W-1:H] : b[H-1:0];
    end

    // Extend each operand to W+1 bits so one signed multiplier serves every mode.
    always_comb begin
        case (mode)
            M_HALF: begin
                x = {{(W+1-H){half_a[H-1]}}, half_a};
                y = {{(W+1-H){half_b[H-1]}}, half_b};
            end
            M_WHALF: begin
                x = {a[W-1], a};
                y = {{(W+1-H){half_b[H-1]}}, half_b};
            end
            M_UMUL, M_UMAC: begin
                x = {1'b0, a};
                y = {1'b0, b};
            end
            M_SMUL, M_SMAC: begin
                x = {a[W-1], a};
                y = {b[W-1], b};
            end
            default: begin
                x = '0;
                y = '0;
            end
        endcase
    end
endmodule

// File: rtl/hsmul_core.sv
module hsmul_core #(
    parameter int W = 32
) (
    input  logic signed [W:0]   x,
    input  logic signed [W:0]   y,
    input  logic                acc_en,
    input  logic [2*W-1:0]      acc,
    output logic [2*W-1:0]      sum
);
    logic signed [2*W+1:0] prod;

    always_comb begin
        prod = x * y;
        sum  = prod[2*W-1:0] + (acc_en ? acc : '0);
    end
endmodule

// File: rtl/hsmul_out.sv
module hsmul_out
    import hsmul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  mode_e               mode,
    input  logic [2*W-1:0]      sum,
    output logic                out_vld,
    output logic [W-1:0]        res_lo,
    output logic [W-1:0]        res_hi
);
    localparam int H = W / 2;

    logic [W-1:0] nxt_lo;
    logic [W-1:0] nxt_hi;

    always_comb begin
        case (mode)
            M_HALF: begin
                nxt_lo = sum[W-1:0];
                nxt_hi = '0;
            end
            M_WHALF: begin
                nxt_lo = sum[W+H-1:H];
                nxt_hi = '0;
            end
            M_UMUL, M_UMAC, M_SMUL, M_SMAC: begin
                nxt_lo = sum[W-1:0];
                nxt_hi = sum[2*W-1:W];
            end
            default: begin
                nxt_lo = '0;
                nxt_hi = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            res_lo  <= '0;
            res_hi  <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                res_lo <= nxt_lo;
                res_hi <= nxt_hi;
            end
        end
    end
endmodule

// File: rtl/hsmul_unit.sv
module hsmul_unit
    import hsmul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [2:0]      op,
    input  logic            sel_a,
    input  logic            sel_b,
    input  logic [W-1:0]    opa,
    input  logic [W-1:0]    opb,
    input  logic [W-1:0]    acc_lo,
    input  logic [W-1:0]    acc_hi,
    output logic            out_vld,
    output logic [W-1:0]    res_lo,
    output logic [W-1:0]    res_hi
);
    mode_e                  mode;
    logic                   acc_en;
    logic signed [W:0]      mx;
    logic signed [W:0]      my;
    logic [2*W-1:0]         sum;

    always_comb begin
        mode   = mode_e'(op);
        acc_en = (mode == M_UMAC) || (mode == M_SMAC);
    end

    hsmul_opsel #(.W(W)) u_sel (
        .mode  (mode),
        .sel_a (sel_a),
        .sel_b (sel_b),
        .a     (opa),
        .b     (opb),
        .x     (mx),
        .y     (my)
    );

    hsmul_core #(.W(W)) u_core (
        .x      (mx),
        .y      (my),
        .acc_en (acc_en),
        .acc    ({acc_hi, acc_lo}),
        .sum    (sum)
    );

    hsmul_out #(.W(W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .mode    (mode),
        .sum     (sum),
        .out_vld (out_vld),
        .res_lo  (res_lo),
        .res_hi  (res_hi)
    );
endmodule

// File: rtl/hsmul_chk.sv
module hsmul_chk #(
    parameter int W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_vld,
    input logic [2:0]      op,
    input logic [W-1:0]    opa,
    input logic [W-1:0]    opb,
    input logic            sel_a,
    input logic            sel_b,
    input logic            out_vld,
    input logic [W-1:0]    res_lo,
    input logic [W-1:0]    res_hi
);
    localparam int H = W / 2;

    // R9: result valid follows request valid by one cycle
    p_vld_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_vld == $past(in_vld)));

    // R10: idle cycles leave the result registers untouched
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_vld)) |-> ($stable(res_lo) && $stable(res_hi)));

    // R3: 32-bit modes clear the high word
    p_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_vld) && ($past(op) <= 3'd1)) |-> (res_hi == '0));

    // R8: reserved codes give zero
    p_rsv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_vld) && ($past(op) >= 3'd6)) |-> (res_lo == '0 && res_hi == '0));

    // R1: halfword-pair result sign follows operand signs when neither half is zero
    p_half_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_vld) && $past(op) == 3'd0
         && ($past(sel_a) ? $past(opa[W-1:H]) : $past(opa[H-1:0])) != '0
         && ($past(sel_b) ? $past(opb[W-1:H]) : $past(opb[H-1:0])) != '0)
        |-> (res_lo[W-1] == ($past(sel_a) ? $past(opa[W-1]) : $past(opa[H-1]))
                          ^ ($past(sel_b) ? $past(opb[W-1]) : $past(opb[H-1]))));

    // R11: reset clears the outputs
    always @(posedge clk) begin
        if (!rst_n && $past(!rst_n)) begin
            a_rst_r11: assert (!out_vld && res_lo == '0 && res_hi == '0);
        end
    end
endmodule

bind hsmul_unit hsmul_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .op      (op),
    .opa     (opa),
    .opb     (opb),
    .sel_a   (sel_a),
    .sel_b   (sel_b),
    .out_vld (out_vld),
    .res_lo  (res_lo),
    .res_hi  (res_hi)
);

// File: tb/sim_hsmul_unit.sv
`timescale 1ns/1ps
module sim_hsmul_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [2:0]  op = '0;
    logic        sel_a = 1'b0;
    logic        sel_b = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] acc_lo = '0;
    logic [31:0] acc_hi = '0;
    logic        out_vld;
    logic [31:0] res_lo;
    logic [31:0] res_hi;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] q_lo[$];
    logic [31:0] q_hi[$];
    string       q_tag[$];
    logic [31:0] last_lo = '0;
    logic [31:0] last_hi = '0;

    always #4 clk = ~clk;

    hsmul_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op),
        .sel_a(sel_a), .sel_b(sel_b), .opa(opa), .opb(opb),
        .acc_lo(acc_lo), .acc_hi(acc_hi),
        .out_vld(out_vld), .res_lo(res_lo), .res_hi(res_hi)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent reference built from wide integer arithmetic
    task automatic model(input logic [2:0] c, input logic sa, input logic sb,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [63:0] acc,
                         output logic [31:0] lo, output logic [31:0] hi, output string tag);
        logic signed [31:0]  ha, hb, p32;
        logic signed [63:0]  wa, wb, sp;
        logic [63:0]         up;
        ha = $signed(sa ? a[31:16] : a[15:0]);
        hb = $signed(sb ? b[31:16] : b[15:0]);
        wa = $signed(a);
        wb = $signed(b);
        lo = '0; hi = '0;
        case (c)
            3'd0: begin p32 = ha * hb; lo = p32; tag = "R1/R3"; end
            3'd1: begin sp = wa * 64'(hb); lo = sp[47:16]; tag = "R2/R3"; end
            3'd2: begin up = {32'd0, a} * {32'd0, b}; {hi, lo} = up; tag = "R4"; end
            3'd3: begin up = {32'd0, a} * {32'd0, b} + acc; {hi, lo} = up; tag = "R5"; end
            3'd4: begin sp = wa * wb; {hi, lo} = sp; tag = "R6"; end
            3'd5: begin sp = wa * wb + $signed(acc); {hi, lo} = sp; tag = "R7"; end
            default: tag = "R8";
        endcase
    endtask

    // Driver: called just after a negative edge, holds one cycle
    task automatic send(input logic [2:0] c, input logic sa, input logic sb,
                        input logic [31:0] a, input logic [31:0] b, input logic [63:0] acc);
        logic [31:0] elo, ehi;
        string t;
        model(c, sa, sb, a, b, acc, elo, ehi, t);
        q_lo.push_back(elo);
        q_hi.push_back(ehi);
        q_tag.push_back({t, "/R9"});
        last_lo = elo;
        last_hi = ehi;
        in_vld = 1'b1; op = c; sel_a = sa; sel_b = sb;
        opa = a; opb = b; {acc_hi, acc_lo} = acc;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            opa = $urandom; opb = $urandom; op = 3'($urandom);
            @(negedge clk);
        end
        // R10: outputs still hold the last result
        check("R10", {res_hi, res_lo}, {last_hi, last_lo});
    endtask

    // Monitor: pops and compares every emitted result
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (q_lo.size() == 0) begin
                check("R9 unexpected", 64'd1, 64'd0);
            end else begin
                string t;
                logic [31:0] elo, ehi;
                elo = q_lo.pop_front();
                ehi = q_hi.pop_front();
                t = q_tag.pop_front();
                check(t, {res_hi, res_lo}, {ehi, elo});
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", {31'd0, out_vld, res_hi, res_lo}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle", {63'd0, out_vld}, 64'd0);

        // Corner cases
        send(3'd0, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_8000, 64'd0);    // R1
        send(3'd0, 1'b1, 1'b0, 32'h8000_1234, 32'hFFFF_8000, 64'd0);    // R1 top of a
        send(3'd0, 1'b1, 1'b1, 32'hFFFF_0000, 32'hFFFF_0000, 64'd0);    // R1 -1*-1
        send(3'd1, 1'b0, 1'b0, 32'h8000_0000, 32'h0000_8000, 64'd0);    // R2
        send(3'd1, 1'b1, 1'b1, 32'h8000_0000, 32'h8000_0000, 64'd0);    // R2, sel_a ignored
        send(3'd1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0);    // R2 all ones
        idle(3);
        send(3'd2, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0);    // R4
        send(3'd3, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF); // R5 wrap
        send(3'd4, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0);    // R6
        send(3'd4, 1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000, 64'd0);    // R6
        send(3'd5, 1'b0, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF); // R7
        send(3'd6, 1'b1, 1'b1, 32'h1234_5678, 32'h9ABC_DEF0, 64'd5);    // R8
        send(3'd7, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd5);    // R8
        idle(2);

        // Random bursts and gaps
        for (int k = 0; k < 300; k++) begin
            send(3'($urandom), 1'($urandom), 1'($urandom), $urandom, $urandom,
                 {$urandom, $urandom});
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 4));
        end
        idle(2);
        check("R9 drained", 64'(q_lo.size()), 64'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule